// File: doc/BRIEF.md
# Grouped GPIO Interrupt Aggregator

This block watches a 32-pin input port and turns selected pin activity into interrupt requests. Each pin passes through a two-flop synchroniser. It then goes to an event detector that follows the pin's own 2-bit trigger mode: low level, high level, rising edge or falling edge. A detected event sets a sticky per-pin status bit. Software learns which pin fired by reading the status word, and it clears bits by writing ones to them.

Status bits reach the outputs through a per-pin gate register. A gated-off pin still records its events but drives no request. The gated status is reduced to two half-port requests: one covers pins 0–15 and the other covers pins 16–31. The lowest eight pins also drive their own dedicated request lines, so a handler can serve them without decoding the group. The register port is a plain single-cycle write strobe with a combinational read path. It has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `gpio_irq_agg`

## Requirements
- R1: While `rst_ni` is low, every register is cleared: all modes are 00, the gate is 0 and the status is 0. All request outputs are low.
- R2: The register map uses word addresses. Address 0 holds the modes of pins 0–15 and address 1 holds the modes of pins 16–31. Pin i uses bits [2(i mod 16)+1 : 2(i mod 16)] of its word. Address 2 is the gate (bit i for pin i) and address 3 is the status. Any other address reads 0. Mode words and the gate read back the value last written.
- R3: The mode encodings are 00 = low level, 01 = high level, 10 = rising edge and 11 = falling edge. An edge mode records exactly one event per qualifying edge. In edge modes the opposite edge records nothing.
- R4: A pin change applied before a clock edge appears in the status after the third rising edge, counting that edge. It does not appear after the second.
- R5: In a level mode the status bit is set again on every cycle while the level persists, so a clear does not stick.
- R6: Writing address 3 clears every status bit written as 1 and leaves bits written as 0 unchanged. An event in the same cycle as a clear leaves its bit set.
- R7: A pin whose gate bit is 0 still records status but contributes to no output.
- R8: `irq_grp_o[0]` is the OR of the gated status of pins 0–15. `irq_grp_o[1]` is the OR of the gated status of pins 16–31.
- R9: `irq_pin_o[i]` for i = 0..7 equals the gated status of pin i. Pins 8–31 are visible only through `irq_grp_o`, so an asserted dedicated line always comes with an asserted low group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_grp_o | output | 2 | Half-port requests: bit 0 for pins 0–15, bit 1 for pins 16–31 |
| irq_pin_o | output | 8 | Dedicated requests for pins 0–7 |

## Verification
The assertions assume that the pins are quiet or settled around reset release, because edge history starts from zero. They also assume that the write strobe, address and data are steady around the sampling clock edge. The stimulus changes pins and register inputs only on the falling clock edge and holds the pins low during reset. Random pin toggles are sparse, so both the edge and the level modes see isolated events as well as bursts. A cycle-level reference model in the bench follows the same rules from time zero, and directed steps pin down the R4 latency and the set-over-clear case.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int MODE_BITS = 2;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // Warm-up count so the delay check never looks back into reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_sync_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         sync_i,
  input  logic [W*MODE_BITS-1:0] mode_i,
  output logic [W-1:0]         evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    trig_e trig;
    assign trig = trig_e'(mode_i[i*MODE_BITS +: MODE_BITS]);

    always_comb begin
      unique case (trig)
        TRIG_LOW:  evt_o[i] = ~sync_i[i];
        TRIG_HIGH: evt_o[i] = sync_i[i];
        TRIG_RISE: evt_o[i] = sync_i[i] & ~prev_q[i];
        TRIG_FALL: evt_o[i] = ~sync_i[i] & prev_q[i];
        default:   evt_o[i] = 1'b0;
      endcase
    end

    // An edge-mode event cannot repeat on the next cycle while the mode holds.
    p_edge_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[i] && mode_i[i*MODE_BITS+1])
        |=> !(evt_o[i] && $stable(mode_i[i*MODE_BITS +: MODE_BITS])));
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic [W-1:0]           evt_i,
  output logic [W*MODE_BITS-1:0] mode_o,
  output logic [W-1:0]           gate_o,
  output logic [W-1:0]           status_o,
  output logic [W-1:0]           rdata_o
);
  localparam int NMW    = MODE_BITS;   // mode words, one W-bit word per W/2 pins
  localparam int A_GATE = NMW;
  localparam int A_STAT = NMW + 1;

  logic [W*MODE_BITS-1:0] mode_q;
  logic [W-1:0]           gate_q;
  logic [W-1:0]           status_q;
  logic                   stat_wr;
  logic [W-1:0]           clr;

  for (genvar k = 0; k < NMW; k++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q[k*W +: W] <= '0;
      else if (we_i && addr_i == ADDR_W'(k)) mode_q[k*W +: W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else if (we_i && addr_i == ADDR_W'(A_GATE)) gate_q <= wdata_i;
  end

  assign stat_wr = we_i && (addr_i == ADDR_W'(A_STAT));
  assign clr     = stat_wr ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | evt_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NMW; k++) begin
      if (addr_i == ADDR_W'(k)) rdata_o = mode_q[k*W +: W];
    end
    if (addr_i == ADDR_W'(A_GATE)) rdata_o = gate_q;
    if (addr_i == ADDR_W'(A_STAT)) rdata_o = status_q;
  end

  assign mode_o   = mode_q;
  assign gate_o   = gate_q;
  assign status_o = status_q;

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> ((status_q & $past(wdata_i & ~evt_i)) == '0));

  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int W     = 32,
  parameter int GROUP = 16,
  parameter int NDED  = 8,
  localparam int NGRP = W / GROUP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    status_i,
  input  logic [W-1:0]    gate_i,
  output logic [NGRP-1:0] grp_o,
  output logic [NDED-1:0] ded_o
);
  logic [W-1:0] live;
  assign live = status_i & gate_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_o[g] = |live[g*GROUP +: GROUP];
  end

  for (genvar i = 0; i < NDED; i++) begin : g_ded
    assign ded_o[i] = live[i];

    p_pin_in_group_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ded_o[i] |-> grp_o[i / GROUP]);
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int GROUP  = 16,
  parameter int NDED   = 8,
  parameter int ADDR_W = 3,
  localparam int NGRP  = NPINS / GROUP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NPINS-1:0]  reg_wdata_i,
  output logic [NPINS-1:0]  reg_rdata_o,
  output logic [NGRP-1:0]   irq_grp_o,
  output logic [NDED-1:0]   irq_pin_o
);
  logic [NPINS-1:0]           pin_sync;
  logic [NPINS-1:0]           evt;
  logic [NPINS*MODE_BITS-1:0] mode;
  logic [NPINS-1:0]           gate;
  logic [NPINS-1:0]           status;

  gpio_irq_sync #(.W(NPINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (pin_sync)
  );

  gpio_irq_detect #(.W(NPINS)) i_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (pin_sync),
    .mode_i (mode),
    .evt_o  (evt)
  );

  gpio_irq_regs #(.W(NPINS), .ADDR_W(ADDR_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .evt_i    (evt),
    .mode_o   (mode),
    .gate_o   (gate),
    .status_o (status),
    .rdata_o  (reg_rdata_o)
  );

  gpio_irq_merge #(.W(NPINS), .GROUP(GROUP), .NDED(NDED)) i_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status),
    .gate_i   (gate),
    .grp_o    (irq_grp_o),
    .ded_o    (irq_pin_o)
  );

  // R1: outputs stay low while reset is applied.
  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert ((irq_grp_o == '0) && (irq_pin_o == '0));
    end
  end
endmodule

// File: tb/test_gpio_irq_agg.sv
`timescale 1ns/1ps
module test_gpio_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  grp;
  logic [7:0]  ded;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_irq_agg i_gpio_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_grp_o(grp), .irq_pin_o(ded)
  );

  // Reference model, built from the requirements.
  logic [31:0] m_s1, m_s2, m_prev, m_stat, m_gate;
  logic [63:0] m_mode;

  function automatic logic [31:0] ref_evt(input logic [31:0] s, input logic [31:0] p,
                                          input logic [63:0] md);
    logic [31:0] e;
    for (int i = 0; i < 32; i++) begin
      case (md[2*i +: 2])
        2'b00:   e[i] = ~s[i];
        2'b01:   e[i] = s[i];
        2'b10:   e[i] = s[i] & ~p[i];
        default: e[i] = ~s[i] & p[i];
      endcase
    end
    return e;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [2:0] a);
    case (a)
      3'd0:    return m_mode[31:0];
      3'd1:    return m_mode[63:32];
      3'd2:    return m_gate;
      3'd3:    return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0; m_gate <= '0; m_mode <= '0;
    end else begin
      m_s1   <= pins;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_stat <= (m_stat & ~((we && addr == 3'd3) ? wdata : 32'h0))
                | ref_evt(m_s2, m_prev, m_mode);
      if (we && addr == 3'd0) m_mode[31:0]  <= wdata;
      if (we && addr == 3'd1) m_mode[63:32] <= wdata;
      if (we && addr == 3'd2) m_gate <= wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    step(3);
    // R1: state while reset is applied
    check("R1 grp in reset", {30'h0, grp}, 32'h0);
    check("R1 ded in reset", {24'h0, ded}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      check("R1 reg in reset", v, 32'h0);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1);
    wr(3'd0, 32'hAAAA_AAAA);
    wr(3'd1, 32'hAAAA_AAAA);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R6 clear all", v, 32'h0);

    // R4/R3/R7: rising edge on pin 3, gate off
    pins[3] = 1'b1;
    step(2);
    rd(3'd3, v); check("R4 not after 2 edges", v, 32'h0);
    step(1);
    rd(3'd3, v); check("R4 after 3 edges", v, 32'h0000_0008);
    check("R7 gated off grp", {30'h0, grp}, 32'h0);
    check("R7 gated off ded", {24'h0, ded}, 32'h0);
    wr(3'd2, 32'h0000_0008);
    check("R9 dedicated pin3", {24'h0, ded}, 32'h0000_0008);
    check("R8 low group", {30'h0, grp}, 32'h1);
    step(3);
    wr(3'd3, 32'h0000_0008);
    rd(3'd3, v); check("R3 edge recorded once", v, 32'h0);
    check("R8 group drops", {30'h0, grp}, 32'h0);

    // R3 falling mode on pin 20 (word 1 bits 9:8 = 11)
    wr(3'd1, 32'hAAAA_ABAA);
    pins[20] = 1'b1;
    step(4);
    rd(3'd3, v); check("R3 rising ignored in fall mode", v, 32'h0);
    pins[20] = 1'b0;
    step(3);
    rd(3'd3, v); check("R3 falling recorded", v, 32'h0010_0000);
    wr(3'd2, 32'h0010_0000);
    check("R8 high group", {30'h0, grp}, 32'h2);
    check("R9 pins above 7 no dedicated", {24'h0, ded}, 32'h0);

    // R5/R6: high level on pin 9 (word 0 bits 19:18 = 01)
    wr(3'd0, 32'hAAA6_AAAA);
    pins[9] = 1'b1;
    step(3);
    wr(3'd3, 32'h0000_0200);
    rd(3'd3, v); check("R5 level re-sets after clear", v, 32'h0010_0200);
    pins[9] = 1'b0;
    step(3);
    wr(3'd3, 32'h0000_0200);
    rd(3'd3, v); check("R6 clear only written ones", v, 32'h0010_0000);

    // R2 map and R3 low level on pin 16 (word 1 bits 1:0 = 00)
    rd(3'd0, v); check("R2 mode word 0", v, 32'hAAA6_AAAA);
    rd(3'd2, v); check("R2 gate", v, 32'h0010_0000);
    rd(3'd5, v); check("R2 unmapped", v, 32'h0);
    wr(3'd1, 32'hAAAA_ABA8);
    step(1);
    rd(3'd3, v); check("R3 low level recorded", v, 32'h0011_0000);

    // Random phase against the model
    for (int c = 0; c < 3000; c++) begin
      check("R8 grp model", {30'h0, grp},
            {30'h0, |(m_stat[31:16] & m_gate[31:16]), |(m_stat[15:0] & m_gate[15:0])});
      check("R9 ded model", {24'h0, ded}, {24'h0, m_stat[7:0] & m_gate[7:0]});
      check("R2 rdata model", rdata, ref_rd(addr));
      pins = pins ^ ($urandom & $urandom & $urandom & $urandom);
      we    = ($urandom % 4) == 0;
      addr  = 3'($urandom % 8);
      wdata = $urandom;
      @(negedge clk);
    end
    we = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule